// File: doc/BRIEF.md
# Staged TLB Entry Write and Read Array

This block holds a small, directly indexed table of translation entries together with the staging registers that software fills before it moves an entry in or out of the table. The staging set is a page-size word, an entry-high word (virtual page number and address-space tag), two entry-low words (one per page of the even/odd pair) and a slot pointer. Each is loaded through a simple select/data write port and is visible at all times on its own output.

Three operations act on the table. An indexed write packs the staging words into the slot named by the pointer. A random write packs them into the slot shown by a free-running down-counter. An indexed read unpacks the pointed slot back into the staging words.

On every write the block decodes the page-size mask into an address shift amount and an offset mask, and stores both with the entry. It also forces the coarse minimum page size unless small pages are both enabled and supported. A mask pattern that is not a legal size raises an error flag, and the table is left as it was. Address lookup, miss handling and protected slots are not part of this block.

Top module: `tlb_stage_array`

## Requirements
- R1: A staging write stores `cfg_wdata_i` in the register chosen by `cfg_sel_i`, and the new value shows on that register's output after the next clock edge. The select codes are 0 page mask, 1 entry-high, 2 entry-low even, 3 entry-low odd and 4 slot pointer; codes 5 to 7 change nothing. After reset all staging outputs and the error flag are zero.
- R2: An indexed write (`op_i` = 2'b01) stores an entry built from the staging words into the slot given by the low bits of the slot pointer. The entry holds:
  - the mask, taken from page-mask bits 28:11;
  - the page number, taken from entry-high bits 31:11;
  - the tag, taken from entry-high bits 7:0;
  - for each half, the frame number from bits 31:6, the cache attribute from bits 5:3, the dirty bit from bit 2 and the valid bit from bit 1.
- R3: Unless both `sp_enable_i` and `sp_capable_i` are 1, a write forces mask bits 1:0 to 1 and page-number bits 1:0 to 0.
- R4: The stored global bit is entry-low-even bit 0 AND entry-low-odd bit 0. A read returns that global bit in bit 0 of both entry-low words.
- R5: The shift amount is 10 for an all-zero mask and 12 for mask 0b11, and it grows by 2 for each further pair of contiguous low ones, up to 28 for 18 ones. The stored offset mask is 2 to the power of the shift amount, minus 1. A read presents both values on `rd_shift_o` and `rd_offmask_o`.
- R6: A write whose mask, after the forcing of R3, is not one of the legal patterns sets `err_o` and leaves the table unchanged. A write with a legal mask clears `err_o`.
- R7: Bit 31 of the slot pointer is ignored when a slot is chosen. The full 32-bit pointer value is still kept and shown.
- R8: The random slot counter resets to ENTRIES-1, decrements on every clock and wraps from 0 to ENTRIES-1. A random write (`op_i` = 2'b10) targets the value shown on `rnd_slot_o` in the cycle the operation is presented.
- R9: An indexed read (`op_i` = 2'b11) rebuilds the staging words from the pointed slot:
  - the page mask is the mask shifted left by 11;
  - entry-high is the page number shifted left by 11, ORed with the tag;
  - each entry-low is frame<<6 | attribute<<3 | dirty<<2 | valid<<1 | global.
- R10: When a staging write and an operation fall in the same cycle, the operation uses the staging values from before that cycle. A read's rebuild of the page mask, entry-high and entry-low words takes precedence over the staging write. A staging write to the slot pointer, or any staging write alongside a table write, still takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Staging register write strobe |
| cfg_sel_i | input | 3 | Staging register select |
| cfg_wdata_i | input | 32 | Staging register write data |
| op_i | input | 2 | Table operation: 00 idle, 01 indexed write, 10 random write, 11 indexed read |
| sp_enable_i | input | 1 | Small-page enable |
| sp_capable_i | input | 1 | Small-page capability |
| pagemask_o | output | 32 | Page-mask staging register |
| entryhi_o | output | 32 | Entry-high staging register |
| entrylo0_o | output | 32 | Entry-low even staging register |
| entrylo1_o | output | 32 | Entry-low odd staging register |
| index_o | output | 32 | Slot pointer staging register |
| err_o | output | 1 | Illegal mask flag from the last write |
| rnd_slot_o | output | $clog2(ENTRIES) | Current random slot |
| rd_shift_o | output | 5 | Shift amount of the last entry read |
| rd_offmask_o | output | 28 | Offset mask of the last entry read |

## Verification
A staging register write and a table operation can land on the same clock edge. The bench provokes this in three ways:
- a read together with a staging write to entry-high;
- a read together with a staging write to the slot pointer;
- an indexed write together with a staging write to the page mask.

In each case it judges the result from both sides. It checks the staging outputs after the edge, which show whether the read rebuild or the software value won. It then reads the table back, which shows that the operation used the staging values from before the edge.

// File: rtl/tlb_stage_pkg.sv
package tlb_stage_pkg;

    localparam int WORD_W    = 32;
    localparam int MASK_W    = 18;
    localparam int VPN_W     = 21;
    localparam int ASID_W    = 8;
    localparam int PFN_W     = 26;
    localparam int CA_W      = 3;
    localparam int SH_W      = 5;
    localparam int OFF_W     = 28;
    localparam int MASK_LSB  = 11;
    localparam int PFN_LSB   = 6;
    localparam int NUM_SIZES = MASK_W / 2 + 1;
    localparam int BASE_SH   = 10;

    typedef struct packed {
        logic [PFN_W-1:0] pfn;
        logic [CA_W-1:0]  ca;
        logic             dirty;
        logic             valid;
    } half_t;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        half_t [1:0]       half;
        logic              glob;
        logic [SH_W-1:0]   shift;
        logic [OFF_W-1:0]  offmask;
    } entry_t;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'b00,
        OP_WR_IDX = 2'b01,
        OP_WR_RND = 2'b10,
        OP_RD_IDX = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        SEL_PMASK = 3'd0,
        SEL_EHI   = 3'd1,
        SEL_ELO0  = 3'd2,
        SEL_ELO1  = 3'd3,
        SEL_INDEX = 3'd4
    } sel_e;

endpackage

// File: rtl/tlb_stage_pack.sv
module tlb_stage_pack
    import tlb_stage_pkg::*;
(
    input  logic [WORD_W-1:0] pagemask_i,
    input  logic [WORD_W-1:0] entryhi_i,
    input  logic [WORD_W-1:0] entrylo0_i,
    input  logic [WORD_W-1:0] entrylo1_i,
    input  logic              sp_enable_i,
    input  logic              sp_capable_i,
    output entry_t            ent_o,
    output logic              ok_o
);

    logic [WORD_W-1:0] lo_w [2];
    half_t [1:0]       half_w;
    logic              coarse_w;
    logic [MASK_W-1:0] mask_w;
    logic [VPN_W-1:0]  vpn_w;
    logic [SH_W-1:0]   sh_w;
    logic [OFF_W:0]    off_w;

    assign lo_w[0] = entrylo0_i;
    assign lo_w[1] = entrylo1_i;

    for (genvar h = 0; h < 2; h++) begin : g_half
        assign half_w[h].pfn   = lo_w[h][WORD_W-1:PFN_LSB];
        assign half_w[h].ca    = lo_w[h][5:3];
        assign half_w[h].dirty = lo_w[h][2];
        assign half_w[h].valid = lo_w[h][1];
    end

    always_comb begin
        coarse_w = !(sp_enable_i && sp_capable_i);
        mask_w   = pagemask_i[MASK_LSB +: MASK_W];
        vpn_w    = entryhi_i[WORD_W-1:MASK_LSB];
        if (coarse_w) begin
            mask_w[1:0] = 2'b11;
            vpn_w[1:0]  = 2'b00;
        end
        ok_o = 1'b0;
        sh_w = '0;
        for (int k = 0; k < NUM_SIZES; k++) begin
            if (mask_w == MASK_W'((1 << (2 * k)) - 1)) begin
                ok_o = 1'b1;
                sh_w = SH_W'(BASE_SH + 2 * k);
            end
        end
        off_w = ((OFF_W+1)'(1) << sh_w) - (OFF_W+1)'(1);
    end

    always_comb begin
        ent_o.mask    = mask_w;
        ent_o.vpn     = vpn_w;
        ent_o.asid    = entryhi_i[ASID_W-1:0];
        ent_o.half    = half_w;
        ent_o.glob    = entrylo0_i[0] & entrylo1_i[0];
        ent_o.shift   = sh_w;
        ent_o.offmask = off_w[OFF_W-1:0];
    end

endmodule

// File: rtl/tlb_stage_unpack.sv
module tlb_stage_unpack
    import tlb_stage_pkg::*;
(
    input  entry_t            ent_i,
    output logic [WORD_W-1:0] pagemask_o,
    output logic [WORD_W-1:0] entryhi_o,
    output logic [WORD_W-1:0] entrylo0_o,
    output logic [WORD_W-1:0] entrylo1_o
);

    logic [WORD_W-1:0] lo_w [2];

    for (genvar h = 0; h < 2; h++) begin : g_half
        assign lo_w[h] = {ent_i.half[h].pfn, ent_i.half[h].ca,
                          ent_i.half[h].dirty, ent_i.half[h].valid, ent_i.glob};
    end

    assign pagemask_o = {{(WORD_W-MASK_W-MASK_LSB){1'b0}}, ent_i.mask, {MASK_LSB{1'b0}}};
    assign entryhi_o  = {ent_i.vpn, {(MASK_LSB-ASID_W){1'b0}}, ent_i.asid};
    assign entrylo0_o = lo_w[0];
    assign entrylo1_o = lo_w[1];

endmodule

// File: rtl/tlb_stage_victim.sv
module tlb_stage_victim #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [IDX_W-1:0] slot_o
);

    localparam logic [IDX_W-1:0] TOP = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == '0) ? TOP : cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= TOP;
        else        cnt_q <= cnt_d;
    end

    assign slot_o = cnt_q;

    // R8
    wrap_to_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_o == '0) |=> (slot_o == TOP));

    // R8
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_o != '0) |=> (slot_o == $past(slot_o) - 1'b1));

endmodule

// File: rtl/tlb_stage_array.sv
module tlb_stage_array
    import tlb_stage_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic [2:0]        cfg_sel_i,
    input  logic [31:0]       cfg_wdata_i,
    input  logic [1:0]        op_i,
    input  logic              sp_enable_i,
    input  logic              sp_capable_i,
    output logic [31:0]       pagemask_o,
    output logic [31:0]       entryhi_o,
    output logic [31:0]       entrylo0_o,
    output logic [31:0]       entrylo1_o,
    output logic [31:0]       index_o,
    output logic              err_o,
    output logic [IDX_W-1:0]  rnd_slot_o,
    output logic [4:0]        rd_shift_o,
    output logic [27:0]       rd_offmask_o
);

    typedef struct packed {
        logic [WORD_W-1:0] pmask;
        logic [WORD_W-1:0] ehi;
        logic [WORD_W-1:0] elo0;
        logic [WORD_W-1:0] elo1;
        logic [WORD_W-1:0] index;
        logic              err;
        logic [SH_W-1:0]   rd_shift;
        logic [OFF_W-1:0]  rd_off;
    } stage_t;

    stage_t st_d, st_q;
    entry_t tbl_q [ENTRIES];

    op_e               op_w;
    entry_t            pk_ent;
    logic              pk_ok;
    entry_t            rd_ent;
    logic [WORD_W-1:0] up_pm, up_eh, up_lo0, up_lo1;
    logic [WORD_W-1:0] ptr_w;
    logic [IDX_W-1:0]  ptr_slot;
    logic [IDX_W-1:0]  vic_slot;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_slot;
    logic              is_wr;

    assign op_w     = op_e'(op_i);
    assign ptr_w    = st_q.index & 32'h7FFF_FFFF;
    assign ptr_slot = ptr_w[IDX_W-1:0];
    assign rd_ent   = tbl_q[ptr_slot];
    assign is_wr    = (op_w == OP_WR_IDX) || (op_w == OP_WR_RND);

    tlb_stage_pack u_pack (
        .pagemask_i   (st_q.pmask),
        .entryhi_i    (st_q.ehi),
        .entrylo0_i   (st_q.elo0),
        .entrylo1_i   (st_q.elo1),
        .sp_enable_i  (sp_enable_i),
        .sp_capable_i (sp_capable_i),
        .ent_o        (pk_ent),
        .ok_o         (pk_ok)
    );

    tlb_stage_unpack u_unpack (
        .ent_i      (rd_ent),
        .pagemask_o (up_pm),
        .entryhi_o  (up_eh),
        .entrylo0_o (up_lo0),
        .entrylo1_o (up_lo1)
    );

    tlb_stage_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk    (clk),
        .rst_n  (rst_n),
        .slot_o (vic_slot)
    );

    always_comb begin
        st_d    = st_q;
        wr_en   = 1'b0;
        wr_slot = (op_w == OP_WR_RND) ? vic_slot : ptr_slot;
        if (cfg_we_i) begin
            case (cfg_sel_i)
                SEL_PMASK: st_d.pmask = cfg_wdata_i;
                SEL_EHI:   st_d.ehi   = cfg_wdata_i;
                SEL_ELO0:  st_d.elo0  = cfg_wdata_i;
                SEL_ELO1:  st_d.elo1  = cfg_wdata_i;
                SEL_INDEX: st_d.index = cfg_wdata_i;
                default: ;
            endcase
        end
        case (op_w)
            OP_WR_IDX, OP_WR_RND: begin
                wr_en    = pk_ok;
                st_d.err = !pk_ok;
            end
            OP_RD_IDX: begin
                st_d.pmask    = up_pm;
                st_d.ehi      = up_eh;
                st_d.elo0     = up_lo0;
                st_d.elo1     = up_lo1;
                st_d.rd_shift = rd_ent.shift;
                st_d.rd_off   = rd_ent.offmask;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= '0;
        end else if (wr_en) begin
            tbl_q[wr_slot] <= pk_ent;
        end
    end

    assign pagemask_o   = st_q.pmask;
    assign entryhi_o    = st_q.ehi;
    assign entrylo0_o   = st_q.elo0;
    assign entrylo1_o   = st_q.elo1;
    assign index_o      = st_q.index;
    assign err_o        = st_q.err;
    assign rnd_slot_o   = vic_slot;
    assign rd_shift_o   = st_q.rd_shift;
    assign rd_offmask_o = st_q.rd_off;

    // R6
    bad_mask_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr && !pk_ok) |=> err_o);

    // R6
    good_mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr && pk_ok) |=> !err_o);

    // R3
    coarse_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr && !(sp_enable_i && sp_capable_i))
            |-> (pk_ent.mask[1:0] == 2'b11 && pk_ent.vpn[1:0] == 2'b00));

    // R5
    shift_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr && pk_ok) |-> (pk_ent.shift >= 5'd10 && pk_ent.shift <= 5'd28 && !pk_ent.shift[0]));

    // R9
    read_zero_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_w == OP_RD_IDX) |=> (pagemask_o[10:0] == '0 && entryhi_o[10:8] == '0));

    // R4
    read_glob_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_w == OP_RD_IDX) |=> (entrylo0_o[0] == entrylo1_o[0]));

endmodule

// File: tb/tlb_stage_array_tb.sv
module tlb_stage_array_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES    = 16;
    localparam int IDX_W      = $clog2(ENTRIES);
    localparam int NVEC       = 13;

    typedef struct packed {
        logic [31:0] pm;
        logic [31:0] eh;
        logic [31:0] lo0;
        logic [31:0] lo1;
        logic [31:0] idx;
        logic        en;
        logic        cap;
        logic [4:0]  sh;
        logic        err;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{32'h0000_0000, 32'hABCD_E7FF, 32'h0000_1ABF, 32'h0000_2235, 32'd3,  1'b1, 1'b1, 5'd10, 1'b0},
        '{32'h0000_0000, 32'h0000_1842, 32'h1234_5679, 32'h0FED_CBA8, 32'd4,  1'b1, 1'b0, 5'd12, 1'b0},
        '{32'h0000_7800, 32'h7654_3210, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd6,  1'b1, 1'b1, 5'd14, 1'b0},
        '{32'h1FFF_F800, 32'hFFFF_FFFF, 32'h8000_0041, 32'h0000_00C1, 32'd7,  1'b0, 1'b0, 5'd28, 1'b0},
        '{32'h0001_F800, 32'h0000_3A5A, 32'h0000_0003, 32'h0000_0002, 32'd8,  1'b0, 1'b1, 5'd16, 1'b0},
        '{32'h0000_2800, 32'h5555_5555, 32'h0000_0001, 32'h0000_0001, 32'd3,  1'b1, 1'b1, 5'd0,  1'b1},
        '{32'h0000_2000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'd4,  1'b0, 1'b0, 5'd0,  1'b1},
        '{32'h0007_F800, 32'h0F0F_0F0F, 32'h0000_0101, 32'h0000_0203, 32'h8000_0005, 1'b1, 1'b1, 5'd18, 1'b0},
        '{32'h001F_F800, 32'h0000_0001, 32'h0000_0002, 32'h0000_0003, 32'd15, 1'b1, 1'b1, 5'd20, 1'b0},
        '{32'h007F_F800, 32'h0000_0002, 32'h0000_0004, 32'h0000_0005, 32'd0,  1'b1, 1'b1, 5'd22, 1'b0},
        '{32'h01FF_F800, 32'h0000_0003, 32'h0000_0004, 32'h0000_0005, 32'd1,  1'b1, 1'b1, 5'd24, 1'b0},
        '{32'h07FF_F800, 32'hFEDC_BA98, 32'hAAAA_AAAB, 32'h5555_5555, 32'd2,  1'b1, 1'b1, 5'd26, 1'b0},
        '{32'hE000_1800, 32'hC000_0801, 32'h0000_0077, 32'h0000_0079, 32'd9,  1'b1, 1'b1, 5'd12, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [2:0]       cfg_sel = '0;
    logic [31:0]      cfg_wdata = '0;
    logic [1:0]       op = 2'b00;
    logic             sp_en = 1'b0;
    logic             sp_cap = 1'b0;
    logic [31:0]      pagemask, entryhi, entrylo0, entrylo1, index_r;
    logic             err;
    logic [IDX_W-1:0] rnd_slot;
    logic [4:0]       rd_shift;
    logic [27:0]      rd_offmask;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] m_pm  [ENTRIES];
    logic [31:0] m_eh  [ENTRIES];
    logic [31:0] m_lo0 [ENTRIES];
    logic [31:0] m_lo1 [ENTRIES];
    logic [4:0]  m_sh  [ENTRIES];

    tlb_stage_array #(.ENTRIES(ENTRIES)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we_i     (cfg_we),
        .cfg_sel_i    (cfg_sel),
        .cfg_wdata_i  (cfg_wdata),
        .op_i         (op),
        .sp_enable_i  (sp_en),
        .sp_capable_i (sp_cap),
        .pagemask_o   (pagemask),
        .entryhi_o    (entryhi),
        .entrylo0_o   (entrylo0),
        .entrylo1_o   (entrylo1),
        .index_o      (index_r),
        .err_o        (err),
        .rnd_slot_o   (rnd_slot),
        .rd_shift_o   (rd_shift),
        .rd_offmask_o (rd_offmask)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic cfg(input logic [2:0] sel, input logic [31:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic do_op(input logic [1:0] code);
        op = code;
        step();
        op = 2'b00;
    endtask

    task automatic both(input logic [1:0] code, input logic [2:0] sel, input logic [31:0] data);
        op = code; cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        step();
        op = 2'b00; cfg_we = 1'b0;
    endtask

    // Expected entry contents, derived from R2, R3, R4 and R9.
    task automatic model_store(input int slot, input logic [31:0] pm, input logic [31:0] eh,
                               input logic [31:0] lo0, input logic [31:0] lo1,
                               input logic en, input logic cap, input logic [4:0] sh);
        logic [17:0] m;
        logic [20:0] v;
        logic        g;
        m = pm[28:11];
        v = eh[31:11];
        if (!(en && cap)) begin
            m[1:0] = 2'b11;
            v[1:0] = 2'b00;
        end
        g = lo0[0] & lo1[0];
        m_pm[slot]  = {3'b000, m, 11'b0};
        m_eh[slot]  = {v, 3'b000, eh[7:0]};
        m_lo0[slot] = {lo0[31:1], g};
        m_lo1[slot] = {lo1[31:1], g};
        m_sh[slot]  = sh;
    endtask

    task automatic check_read(input int slot, input string tag);
        logic [28:0] off;
        off = (29'd1 << m_sh[slot]) - 29'd1;
        check({tag, " R9 pagemask"}, pagemask, m_pm[slot]);
        check({tag, " R2 R3 R9 entryhi"}, entryhi, m_eh[slot]);
        check({tag, " R2 R4 entrylo0"}, entrylo0, m_lo0[slot]);
        check({tag, " R2 R4 entrylo1"}, entrylo1, m_lo1[slot]);
        check({tag, " R5 shift"}, {27'd0, rd_shift}, {27'd0, m_sh[slot]});
        check({tag, " R5 offmask"}, {4'd0, rd_offmask}, {4'd0, off[27:0]});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [IDX_W-1:0] prev;
        int               s;
        for (int i = 0; i < ENTRIES; i++) model_store(i, 32'h0, 32'h0, 32'h0, 32'h0, 1'b1, 1'b1, 5'd0);
        for (int i = 0; i < ENTRIES; i++) m_pm[i] = '0;

        // reset state: R1, R8
        #(CLK_PERIOD * 2 + 3);
        check("R1 reset pagemask", pagemask, 32'h0);
        check("R1 reset entryhi", entryhi, 32'h0);
        check("R1 reset index", index_r, 32'h0);
        check("R6 reset err", {31'd0, err}, 32'h0);
        check("R8 reset random slot", {28'd0, rnd_slot}, ENTRIES - 1);
        @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R8 countdown and wrap
        for (int c = 0; c < 20; c++) begin
            prev = rnd_slot;
            step();
            check("R8 countdown", {28'd0, rnd_slot},
                  (prev == '0) ? ENTRIES - 1 : {28'd0, prev - 1'b1});
        end

        // table-driven write/read walk
        for (int i = 0; i < NVEC; i++) begin
            cfg(3'd0, VEC[i].pm);
            cfg(3'd1, VEC[i].eh);
            cfg(3'd2, VEC[i].lo0);
            cfg(3'd3, VEC[i].lo1);
            cfg(3'd4, VEC[i].idx);
            check("R1 staged pagemask", pagemask, VEC[i].pm);
            check("R1 staged entrylo1", entrylo1, VEC[i].lo1);
            check("R1 R7 staged index", index_r, VEC[i].idx);
            sp_en = VEC[i].en;
            sp_cap = VEC[i].cap;
            do_op(2'b01);
            check("R6 error flag", {31'd0, err}, {31'd0, VEC[i].err});
            if (!VEC[i].err)
                model_store(int'(VEC[i].idx[IDX_W-1:0]), VEC[i].pm, VEC[i].eh,
                            VEC[i].lo0, VEC[i].lo1, VEC[i].en, VEC[i].cap, VEC[i].sh);
            cfg(3'd0, 32'hFFFF_FFFF);
            cfg(3'd1, 32'hFFFF_FFFF);
            cfg(3'd2, 32'hFFFF_FFFF);
            cfg(3'd3, 32'h0);
            cfg(3'd7, 32'h1234_5678);
            check("R1 ignored select", index_r, VEC[i].idx);
            do_op(2'b11);
            check_read(int'(VEC[i].idx[IDX_W-1:0]), "R7 R6 table");
        end

        // R6: error cleared by a legal write
        sp_en = 1'b1; sp_cap = 1'b1;
        cfg(3'd0, 32'h0000_2800);
        cfg(3'd4, 32'd10);
        do_op(2'b01);
        check("R6 illegal mask sets flag", {31'd0, err}, 32'd1);
        cfg(3'd0, 32'h0000_1800);
        cfg(3'd1, 32'h0000_0000);
        cfg(3'd2, 32'h0000_0000);
        cfg(3'd3, 32'h0000_0000);
        do_op(2'b01);
        check("R6 legal mask clears flag", {31'd0, err}, 32'd0);
        model_store(10, 32'h0000_1800, 32'h0, 32'h0, 32'h0, 1'b1, 1'b1, 5'd12);

        // R8: random write goes to the shown slot
        cfg(3'd0, 32'h0000_0000);
        cfg(3'd1, 32'h0000_A855);
        cfg(3'd2, 32'h0000_0F07);
        cfg(3'd3, 32'h0000_0F05);
        s = int'(rnd_slot);
        do_op(2'b10);
        model_store(s, 32'h0, 32'h0000_A855, 32'h0000_0F07, 32'h0000_0F05, 1'b1, 1'b1, 5'd10);
        cfg(3'd4, 32'(s));
        do_op(2'b11);
        check_read(s, "R8 random write");

        // R10: read together with entry-high write, read rebuild wins
        cfg(3'd4, 32'd3);
        both(2'b11, 3'd1, 32'hDEAD_BEEF);
        check("R10 read beats staging write", entryhi, m_eh[3]);
        check("R10 read beats staging write pm", pagemask, m_pm[3]);

        // R10: read together with slot-pointer write, read uses old pointer
        both(2'b11, 3'd4, 32'd6);
        check("R10 pointer write lands", index_r, 32'd6);
        check_read(3, "R10 read used old pointer");

        // R10: indexed write together with page-mask write
        cfg(3'd0, 32'h0000_7800);
        cfg(3'd1, 32'h0000_4321);
        cfg(3'd2, 32'h0000_0040);
        cfg(3'd3, 32'h0000_0080);
        cfg(3'd4, 32'd11);
        both(2'b01, 3'd0, 32'h0000_2800);
        check("R10 staging write lands during write", pagemask, 32'h0000_2800);
        check("R10 write used old mask", {31'd0, err}, 32'd0);
        model_store(11, 32'h0000_7800, 32'h0000_4321, 32'h0000_0040, 32'h0000_0080, 1'b1, 1'b1, 5'd14);
        do_op(2'b11);
        check_read(11, "R10 write used old staging");

        finish_run();
    end

endmodule